// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block is the front end of a multi-sector erase controller. It collects the sectors to be erased before the erase itself starts. The first sector-erase command opens an accumulation window and marks that sector in a bitmap. Every further sector-erase command that arrives while the window is open adds its sector to the bitmap. It also starts the timeout over from zero. The timeout is counted in ticks of a timing strobe.

When the timeout runs out, the selection is frozen and a one-cycle start pulse tells the erase engine to begin. A status bit then reads 1, and from that point on the block ignores every command except erase suspend, until the engine reports that it is done.

A chip-wide erase command skips the window. It starts the engine at once, and the status bit stays 0 for it. A reset command given while the window is open discards the selection without starting an erase. The erase engine, the storage array and the bus timing are outside this block.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `busy`, `window_closed`, `erase_start` and `suspend_req` are 0 and `sector_map` is all zeros.
- R2: In idle, a sector-erase command opens the window. From the next cycle `busy` is 1, `window_closed` is 0 and `sector_map` has only bit `sector_idx` set. Bit i of `sector_map` stands for sector i.
- R3: While the window is open, each sector-erase command sets its bit and starts the timeout over. The window closes on the WINDOW_TICKS-th tick that follows the most recent sector-erase command. A tick that falls in the same cycle as that command is not counted.
- R4: The window advances only on cycles where `tick` is 1. With `tick` held at 0 the window stays open for any number of cycles.
- R5: When the window closes, `window_closed` reads 1 from the next cycle on, and `erase_start` is 1 for exactly that one cycle.
- R6: Once `window_closed` is 1, the sector-erase, reset and chip-erase commands have no effect: `sector_map`, `busy` and `window_closed` keep their values, and no `erase_start` pulse is issued.
- R7: During a sector or chip erase, an erase-suspend command gives a one-cycle `suspend_req` pulse in the next cycle. In idle and while the window is open, erase-suspend has no effect.
- R8: During a sector or chip erase, `erase_done` returns the block to idle in the next cycle, with `busy` 0, `window_closed` 0 and `sector_map` all zeros.
- R9: A reset command while the window is open returns the block to idle in the next cycle, clears `sector_map`, and no `erase_start` pulse follows.
- R10: In idle, a chip-erase command gives an `erase_start` pulse in the next cycle and sets `busy`. `window_closed` stays 0 and `sector_map` stays all zeros until `erase_done`.
- R11: A chip-erase command while the window is open is ignored. The window and its count go on as if the command had not been given.
- R12: In idle, simultaneous commands are resolved with reset first, then chip erase, then sector erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing strobe that advances the window |
| cmd_sector_erase | input | 1 | Sector-erase command strobe |
| cmd_suspend | input | 1 | Erase-suspend command strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_chip_erase | input | 1 | Chip-erase command strobe |
| sector_idx | input | $clog2(NUM_SECTORS) | Sector addressed by a sector-erase command |
| erase_done | input | 1 | Erase engine reports completion |
| window_closed | output | 1 | Timer status: 0 while the window is open, 1 once the sector erase has begun |
| erase_start | output | 1 | One-cycle pulse that starts the erase engine |
| suspend_req | output | 1 | One-cycle pulse that forwards an erase-suspend command to the engine |
| sector_map | output | NUM_SECTORS | Selected sectors |
| busy | output | 1 | Window open or erase in progress |

## Verification
The bench builds the block with NUM_SECTORS = 8 and WINDOW_TICKS = 4. A four-tick window makes it possible to pin down the closing edge exactly, counting from the last restart. With eight sectors, two or three accumulated bits give bitmap values that can be told apart. The bench drives `tick` freely, so it can show that a window with no ticks stays open. It also places a restart and a chip-erase command partway through a window and checks that the close arrives at exactly the cycle the count predicts.

// File: rtl/sew_pkg.sv
// Package: shared state encoding for the sector erase accumulation window.
// Assumes: no parameters; width-dependent items are derived in each module.
package sew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ERASE  = 2'd2,
        ST_CHIP   = 2'd3
    } sew_state_t;
endpackage

// File: rtl/sew_tick_timer.sv
// Module: window timeout counter. It counts tick strobes while run is high.
// restart clears the count. expire is asserted combinationally on the
// tick that completes LIMIT ticks.
// Assumes: LIMIT >= 1; the owner drops run after expire.
module sew_tick_timer #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Count ticks; hold at zero when idle or on a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the tick that completes the timeout.
    always_comb begin
        expire = run && !restart && tick && (cnt == LAST);
    end
endmodule

// File: rtl/sew_sector_map.sv
// Module: sector selection bitmap. set ORs in the bit that idx selects,
// and clr empties the whole map (clr wins).
// Assumes: idx values at or above NUM_SECTORS select no bit.
module sew_sector_map #(
    parameter int NUM_SECTORS = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set,
    input  logic                   clr,
    input  logic [IW-1:0]          idx,
    output logic [NUM_SECTORS-1:0] map
);
    localparam int IW = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

    logic [NUM_SECTORS-1:0] hit;

    // One decoder comparator per sector.
    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_dec
        assign hit[i] = (idx == IW'(i));
    end

    // Accumulate selected sectors; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            map <= '0;
        end else if (set) begin
            map <= map | hit;
        end
    end
endmodule

// File: rtl/sew_ctrl.sv
// Module: command sequencer. It decodes the command strobes against the
// current state, steers the timer and the bitmap, and registers the start
// and suspend pulses.
// Assumes: strobes are one cycle wide per command; in idle the priority is
// reset > chip > sector.
module sew_ctrl
    import sew_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_sector_erase,
    input  logic       cmd_suspend,
    input  logic       cmd_reset,
    input  logic       cmd_chip_erase,
    input  logic       erase_done,
    input  logic       expire,
    output sew_state_t state,
    output logic       map_set,
    output logic       map_clr,
    output logic       timer_run,
    output logic       timer_restart,
    output logic       erase_start,
    output logic       suspend_req
);
    sew_state_t nxt;
    logic       start_nxt;
    logic       susp_nxt;

    // Next-state and control decode.
    always_comb begin
        nxt           = state;
        map_set       = 1'b0;
        map_clr       = 1'b0;
        timer_restart = 1'b0;
        start_nxt     = 1'b0;
        susp_nxt      = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_reset) begin
                    nxt = ST_IDLE;
                end else if (cmd_chip_erase) begin
                    nxt       = ST_CHIP;
                    start_nxt = 1'b1;
                end else if (cmd_sector_erase) begin
                    nxt           = ST_WINDOW;
                    map_set       = 1'b1;
                    timer_restart = 1'b1;
                end
            end
            ST_WINDOW: begin
                if (cmd_reset) begin
                    nxt     = ST_IDLE;
                    map_clr = 1'b1;
                end else if (cmd_sector_erase) begin
                    map_set       = 1'b1;
                    timer_restart = 1'b1;
                end else if (expire) begin
                    nxt       = ST_ERASE;
                    start_nxt = 1'b1;
                end
            end
            default: begin
                susp_nxt = cmd_suspend;
                if (erase_done) begin
                    nxt     = ST_IDLE;
                    map_clr = 1'b1;
                end
            end
        endcase
        timer_run = (state == ST_WINDOW);
    end

    // State and output pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            erase_start <= 1'b0;
            suspend_req <= 1'b0;
        end else begin
            state       <= nxt;
            erase_start <= start_nxt;
            suspend_req <= susp_nxt;
        end
    end
endmodule

// File: rtl/sector_erase_window.sv
// Module: top of the sector erase accumulation window. It ties the
// sequencer, the window timer and the sector bitmap together and derives
// the status outputs from the registered state.
// Assumes: tick is a one-cycle strobe; WINDOW_TICKS ticks make the nominal
// 50 us window.
module sector_erase_window
    import sew_pkg::*;
#(
    parameter int NUM_SECTORS  = 64,
    parameter int WINDOW_TICKS = 2500,
    localparam int IW = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   cmd_sector_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_reset,
    input  logic                   cmd_chip_erase,
    input  logic [IW-1:0]          sector_idx,
    input  logic                   erase_done,
    output logic                   window_closed,
    output logic                   erase_start,
    output logic                   suspend_req,
    output logic [NUM_SECTORS-1:0] sector_map,
    output logic                   busy
);
    sew_state_t state;
    logic       map_set;
    logic       map_clr;
    logic       timer_run;
    logic       timer_restart;
    logic       expire;

    sew_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_sector_erase (cmd_sector_erase),
        .cmd_suspend      (cmd_suspend),
        .cmd_reset        (cmd_reset),
        .cmd_chip_erase   (cmd_chip_erase),
        .erase_done       (erase_done),
        .expire           (expire),
        .state            (state),
        .map_set          (map_set),
        .map_clr          (map_clr),
        .timer_run        (timer_run),
        .timer_restart    (timer_restart),
        .erase_start      (erase_start),
        .suspend_req      (suspend_req)
    );

    sew_tick_timer #(.LIMIT(WINDOW_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .restart (timer_restart),
        .tick    (tick),
        .expire  (expire)
    );

    sew_sector_map #(.NUM_SECTORS(NUM_SECTORS)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (map_set),
        .clr   (map_clr),
        .idx   (sector_idx),
        .map   (sector_map)
    );

    // Status flags decoded from the registered state.
    always_comb begin
        window_closed = (state == ST_ERASE);
        busy          = (state != ST_IDLE);
    end
endmodule

// File: rtl/sew_checks.sv
// Module: property checker for sector_erase_window, attached by bind.
// Assumes: observes top-level ports only.
module sew_checks #(
    parameter int NUM_SECTORS = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   erase_done,
    input logic                   window_closed,
    input logic                   erase_start,
    input logic                   suspend_req,
    input logic [NUM_SECTORS-1:0] sector_map,
    input logic                   busy
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !erase_start && !suspend_req && sector_map == '0)); // R1

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start); // R5

    AST_CLOSE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_closed) |-> erase_start); // R5

    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (window_closed && !erase_done) |=> (window_closed && $stable(sector_map))); // R6

    AST_SUSPEND_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(busy)); // R7

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sector_map == '0 && !window_closed)); // R8

    AST_CHIP_NO_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sector_map == '0) |-> !window_closed); // R10
endmodule

bind sector_erase_window sew_checks #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .erase_done    (erase_done),
    .window_closed (window_closed),
    .erase_start   (erase_start),
    .suspend_req   (suspend_req),
    .sector_map    (sector_map),
    .busy          (busy)
);

// File: tb/sector_erase_window_test.sv
// Bench: directed scenarios, one task each. Inputs are driven at the
// negative edge and outputs sampled at the next negative edge.
module sector_erase_window_test;
    localparam int N  = 8;
    localparam int WT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_sector_erase = 1'b0;
    logic       cmd_suspend = 1'b0;
    logic       cmd_reset = 1'b0;
    logic       cmd_chip_erase = 1'b0;
    logic [2:0] sector_idx = '0;
    logic       erase_done = 1'b0;
    logic       window_closed;
    logic       erase_start;
    logic       suspend_req;
    logic [N-1:0] sector_map;
    logic       busy;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 1'b0;

    always #10 clk = ~clk;

    sector_erase_window #(.NUM_SECTORS(N), .WINDOW_TICKS(WT)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .tick             (tick),
        .cmd_sector_erase (cmd_sector_erase),
        .cmd_suspend      (cmd_suspend),
        .cmd_reset        (cmd_reset),
        .cmd_chip_erase   (cmd_chip_erase),
        .sector_idx       (sector_idx),
        .erase_done       (erase_done),
        .window_closed    (window_closed),
        .erase_start      (erase_start),
        .suspend_req      (suspend_req),
        .sector_map       (sector_map),
        .busy             (busy)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input logic b, input logic wc,
                                input logic [N-1:0] m);
        expect_eq(req, "busy", 32'(busy), 32'(b));
        expect_eq(req, "window_closed", 32'(window_closed), 32'(wc));
        expect_eq(req, "sector_map", 32'(sector_map), 32'(m));
    endtask

    task automatic sector_cmd(input int idx);
        cmd_sector_erase = 1'b1;
        sector_idx = 3'(idx);
        step();
        cmd_sector_erase = 1'b0;
    endtask

    task automatic finish_erase();
        erase_done = 1'b1;
        step();
        erase_done = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        expect_state("R1", 1'b0, 1'b0, '0);
        expect_eq("R1", "erase_start", 32'(erase_start), 0);
        expect_eq("R1", "suspend_req", 32'(suspend_req), 0);
    endtask

    // R2 R5 R8: single-sector window with free-running tick
    task automatic t_single();
        tick = 1'b1;
        sector_cmd(3);
        expect_state("R2", 1'b1, 1'b0, 8'h08);
        steps(WT - 1);
        expect_eq("R3", "window_closed before timeout", 32'(window_closed), 0);
        expect_eq("R5", "erase_start before timeout", 32'(erase_start), 0);
        step();
        expect_eq("R5", "window_closed at timeout", 32'(window_closed), 1);
        expect_eq("R5", "erase_start at timeout", 32'(erase_start), 1);
        step();
        expect_eq("R5", "erase_start single cycle", 32'(erase_start), 0);
        finish_erase();
        expect_state("R8", 1'b0, 1'b0, '0);
        tick = 1'b0;
    endtask

    // R3: additional sectors restart the window
    task automatic t_restart();
        tick = 1'b1;
        sector_cmd(1);
        steps(2);
        sector_cmd(5);
        expect_state("R3", 1'b1, 1'b0, 8'h22);
        steps(WT - 1);
        expect_eq("R3", "still open after restart", 32'(window_closed), 0);
        step();
        expect_eq("R3", "closed after restart", 32'(window_closed), 1);
        expect_eq("R3", "start after restart", 32'(erase_start), 1);
        tick = 1'b0;
    endtask

    // R6 R7 R8: commands after close; run right after t_restart
    task automatic t_ignored();
        sector_cmd(7);
        expect_state("R6", 1'b1, 1'b1, 8'h22);
        cmd_reset = 1'b1;
        step();
        cmd_reset = 1'b0;
        expect_state("R6", 1'b1, 1'b1, 8'h22);
        cmd_chip_erase = 1'b1;
        step();
        cmd_chip_erase = 1'b0;
        expect_eq("R6", "no start on chip cmd", 32'(erase_start), 0);
        expect_state("R6", 1'b1, 1'b1, 8'h22);
        cmd_suspend = 1'b1;
        step();
        cmd_suspend = 1'b0;
        expect_eq("R7", "suspend pulse", 32'(suspend_req), 1);
        step();
        expect_eq("R7", "suspend pulse single", 32'(suspend_req), 0);
        finish_erase();
        expect_state("R8", 1'b0, 1'b0, '0);
    endtask

    // R9: reset command inside the window
    task automatic t_abort();
        tick = 1'b1;
        sector_cmd(2);
        cmd_reset = 1'b1;
        step();
        cmd_reset = 1'b0;
        expect_state("R9", 1'b0, 1'b0, '0);
        for (int i = 0; i < WT + 2; i++) begin
            step();
            expect_eq("R9", "no start after abort", 32'(erase_start), 0);
        end
        tick = 1'b0;
    endtask

    // R10 R7: chip erase bypasses the window
    task automatic t_chip();
        tick = 1'b1;
        cmd_chip_erase = 1'b1;
        step();
        cmd_chip_erase = 1'b0;
        expect_eq("R10", "chip start", 32'(erase_start), 1);
        expect_state("R10", 1'b1, 1'b0, '0);
        steps(WT + 2);
        expect_state("R10", 1'b1, 1'b0, '0);
        cmd_suspend = 1'b1;
        step();
        cmd_suspend = 1'b0;
        expect_eq("R7", "suspend in chip erase", 32'(suspend_req), 1);
        finish_erase();
        expect_state("R8", 1'b0, 1'b0, '0);
        tick = 1'b0;
    endtask

    // R4 R7: no ticks keeps the window open; suspend ignored in window
    task automatic t_no_tick();
        tick = 1'b0;
        sector_cmd(0);
        cmd_suspend = 1'b1;
        step();
        cmd_suspend = 1'b0;
        expect_eq("R7", "no suspend in window", 32'(suspend_req), 0);
        steps(10);
        expect_state("R4", 1'b1, 1'b0, 8'h01);
        tick = 1'b1;
        steps(WT - 1);
        expect_eq("R4", "open before ticks done", 32'(window_closed), 0);
        step();
        expect_eq("R4", "closed after ticks", 32'(window_closed), 1);
        tick = 1'b0;
        finish_erase();
    endtask

    // R11: chip erase inside the window does not disturb the count
    task automatic t_chip_in_window();
        tick = 1'b1;
        sector_cmd(4);
        cmd_chip_erase = 1'b1;
        step();
        cmd_chip_erase = 1'b0;
        expect_eq("R11", "no start on chip in window", 32'(erase_start), 0);
        expect_state("R11", 1'b1, 1'b0, 8'h10);
        steps(WT - 2);
        expect_eq("R11", "still open", 32'(window_closed), 0);
        step();
        expect_eq("R11", "closed on schedule", 32'(window_closed), 1);
        tick = 1'b0;
        finish_erase();
    endtask

    // R12: priority of simultaneous commands in idle
    task automatic t_priority();
        cmd_reset = 1'b1;
        cmd_chip_erase = 1'b1;
        cmd_sector_erase = 1'b1;
        sector_idx = 3'd6;
        step();
        expect_state("R12", 1'b0, 1'b0, '0);
        cmd_reset = 1'b0;
        step();
        cmd_chip_erase = 1'b0;
        cmd_sector_erase = 1'b0;
        expect_eq("R12", "chip wins over sector", 32'(erase_start), 1);
        expect_state("R12", 1'b1, 1'b0, '0);
        finish_erase();
    endtask

    initial begin
        steps(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_single();
        t_restart();
        t_ignored();
        t_abort();
        t_chip();
        t_no_tick();
        t_chip_in_window();
        t_priority();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule